// File: doc/BRIEF.md
# Three-Pair Complementary PWM Generator with Dead Time

This block drives three pairs of PWM outputs (a top and a bottom line per pair) from one shared up-counter whose modulus is programmable, so the switching frequency can be set to any whole number of clock cycles. The counter runs either edge-aligned (a sawtooth) or center-aligned (up then down). Each pair runs either as a complementary half-bridge drive, where the bottom line is the inverse of the top line with a programmable blanking gap around every switch, or as two unrelated PWM lines with their own duty values.

Software writes the configuration through a simple single-cycle write port. Modulus and duty values are written into shadow registers and copied into the working registers only at a reload event, which happens once every N counter periods (N from 1 to 16). Each reload raises a sticky interrupt flag. A synchronous fault input forces every output to its inactive level at once and latches a fault flag, and a write-once lock freezes the pair modes, the polarity selects and the dead time until the next reset.

Top module: `cpwm_dt`

## Requirements
- R1: After reset every output pin is low (inactive with the default polarity), reload_irq is 0 and fault_flag is 0; the counter is stopped.
- R2: With pair bit k of the configuration word (address 1, bits [2:0]) at 0, pair k is complementary: its top and bottom lines are never active together, and the dead time (address 1, bits [11:8], in clock cycles) is removed from the start of each active stretch, so per period the top is active duty-dt cycles and the bottom (period-duty)-dt cycles.
- R3: With pair bit k set to 1, the top line follows the top duty (address 3+k) and the bottom line follows the bottom duty (address 6+k), with no dead time; both may be active together.
- R4: In edge-aligned mode (control word at address 0: bit 0 run, bit 1 = 0) the period is the modulus (address 2, values below 2 act as 2) and an output is active while the count is below its duty.
- R5: In center-aligned mode (control bit 1 = 1) the counter runs 0 up to modulus-1 and back down to 0, each value held for two cycles across a period of twice the modulus; an output is active for twice its duty per period.
- R6: A duty of 0 keeps the line inactive and a duty equal to or above the modulus keeps it active, with no dead-time gap ever appearing on the constant line.
- R7: Modulus and duty writes go to shadow registers and reach the outputs only at a reload event, once every N periods where N is control bits [5:2] plus 1; each reload sets reload_irq, and writing address 10 with bit 0 set clears it.
- R8: Configuration bit 3 inverts all top pins and bit 4 inverts all bottom pins (1 = active low).
- R9: While fault_in is 1 every pin sits at its inactive level in the same cycle, and fault_flag is set at the next clock edge.
- R10: After a fault the pins stay inactive until fault_in is 0 and fault_flag has been cleared (address 10, bit 1); outputs then resume from the next period boundary.
- R11: Writing address 9 with bit 0 set locks the configuration word; later writes to it are ignored until reset, while control, modulus and duty writes still act.
- R12: With the run bit at 0 all pins sit at their inactive level and the counter restarts from zero when run is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| fault_in | input | 1 | Fault request, active high, synchronous to clk |
| pwm_top | output | NPAIR (3) | Top line of each pair, after polarity |
| pwm_bot | output | NPAIR (3) | Bottom line of each pair, after polarity |
| reload_irq | output | 1 | Sticky reload interrupt flag |
| fault_flag | output | 1 | Sticky fault flag |

## Verification
A wrong counter or a stale working register shows as a wrong count of active cycles on a pin within one PWM period, so the bench counts active cycles per pin over whole numbers of periods and compares with duty arithmetic. A dead-time counter that fails to reload shows within one switching edge as both lines of a pair active in the same cycle, which the bench counts as overlap. A reload divider off by one moves the reload flag by a full period, measured as the spacing between two flag events, and a broken fault latch or lock shows immediately as an active pin during a fault or as a changed polarity after a locked write.

// File: rtl/cpwm_pkg.sv
// cpwm_pkg: register addresses and the control word layout shared by the
// PWM generator modules. Assumes a 4-bit word address and 16-bit data.
package cpwm_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MOD  = 4'd2;
    localparam logic [ADDR_W-1:0] A_DTOP = 4'd3;
    localparam logic [ADDR_W-1:0] A_DBOT = 4'd6;
    localparam logic [ADDR_W-1:0] A_LOCK = 4'd9;
    localparam logic [ADDR_W-1:0] A_CLR  = 4'd10;

    // dead-time field starts here inside the configuration word
    localparam int DT_LSB = 8;

    // control word: bits [5:2] reload count minus one, bit 1 center, bit 0 run
    typedef struct packed {
        logic [3:0] div;
        logic       center;
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/cpwm_regs.sv
// cpwm_regs: write-only register file of the PWM generator. Holds the
// control word, the lockable configuration word, the shadow modulus and
// duty registers and the two sticky flags.
// Assumes: one write per cycle; reload_evt and fault_in are synchronous.
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int CNT_W = 8,
    parameter int DT_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        reload_evt,
    input  logic                        fault_in,
    output ctrl_t                       ctrl,
    output logic [NPAIR-1:0]            indep,
    output logic                        pol_top,
    output logic                        pol_bot,
    output logic [DT_W-1:0]             dt,
    output logic [CNT_W-1:0]            mod_buf,
    output logic [NPAIR-1:0][CNT_W-1:0] dtop_buf,
    output logic [NPAIR-1:0][CNT_W-1:0] dbot_buf,
    output logic                        reload_flag,
    output logic                        fault_flag,
    output logic                        locked
);

    localparam int POLT_BIT = NPAIR;
    localparam int POLB_BIT = NPAIR + 1;

    logic wr_ctrl, wr_cfg, wr_mod, wr_lock, wr_clr;
    logic unused_wr;

    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign wr_cfg    = wr_en && (wr_addr == A_CFG);
    assign wr_mod    = wr_en && (wr_addr == A_MOD);
    assign wr_lock   = wr_en && (wr_addr == A_LOCK);
    assign wr_clr    = wr_en && (wr_addr == A_CLR);
    assign unused_wr = ^wr_data;

    // control word: never locked
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(wr_data[5:0]);
    end

    // configuration word: writable only until the lock is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            indep   <= '0;
            pol_top <= 1'b0;
            pol_bot <= 1'b0;
            dt      <= '0;
        end else if (wr_cfg && !locked) begin
            indep   <= wr_data[NPAIR-1:0];
            pol_top <= wr_data[POLT_BIT];
            pol_bot <= wr_data[POLB_BIT];
            dt      <= wr_data[DT_LSB +: DT_W];
        end
    end

    // write-once lock, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)                     locked <= 1'b0;
        else if (wr_lock && wr_data[0]) locked <= 1'b1;
    end

    // shadow modulus and duty registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_buf  <= '0;
            dtop_buf <= '0;
            dbot_buf <= '0;
        end else if (wr_en) begin
            if (wr_mod) mod_buf <= wr_data[CNT_W-1:0];
            for (int k = 0; k < NPAIR; k++) begin
                if (wr_addr == A_DTOP + ADDR_W'(k)) dtop_buf[k] <= wr_data[CNT_W-1:0];
                if (wr_addr == A_DBOT + ADDR_W'(k)) dbot_buf[k] <= wr_data[CNT_W-1:0];
            end
        end
    end

    // sticky flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_flag <= 1'b0;
            fault_flag  <= 1'b0;
        end else begin
            if (reload_evt)               reload_flag <= 1'b1;
            else if (wr_clr && wr_data[0]) reload_flag <= 1'b0;
            if (fault_in)                 fault_flag  <= 1'b1;
            else if (wr_clr && wr_data[1]) fault_flag  <= 1'b0;
        end
    end

    // R11: a locked configuration word never changes
    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> ($stable(indep) && $stable(dt) && $stable(pol_top) && $stable(pol_bot)));

    // R7: the reload flag only rises after a reload event
    assert_reload_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reload_flag) |-> $past(reload_evt));

    // R9: a fault request always leaves the flag set
    assert_fault_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault_in) |-> fault_flag);

endmodule

// File: rtl/cpwm_timebase.sv
// cpwm_timebase: shared PWM counter, reload divider and working duty and
// modulus registers. Produces the raw (pre dead time) request per line.
// Assumes: effective modulus is at least 2; working values follow the
// shadow registers freely while stopped and only at reloads while running.
module cpwm_timebase
    import cpwm_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int CNT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  ctrl_t                       ctrl,
    input  logic [CNT_W-1:0]            mod_buf,
    input  logic [NPAIR-1:0][CNT_W-1:0] dtop_buf,
    input  logic [NPAIR-1:0][CNT_W-1:0] dbot_buf,
    output logic [NPAIR-1:0]            raw_top,
    output logic [NPAIR-1:0]            raw_bot,
    output logic                        period_end,
    output logic                        reload_evt
);

    localparam logic [CNT_W-1:0] MOD_MIN = CNT_W'(2);

    logic [CNT_W-1:0]            cnt;
    logic                        dir_dn;
    logic [3:0]                  per_cnt;
    logic [CNT_W-1:0]            mod_act;
    logic [CNT_W-1:0]            mod_eff;
    logic [NPAIR-1:0][CNT_W-1:0] dtop_act;
    logic [NPAIR-1:0][CNT_W-1:0] dbot_act;
    logic                        at_top;

    assign mod_eff    = (mod_buf < MOD_MIN) ? MOD_MIN : mod_buf;
    assign at_top     = (cnt == mod_act - CNT_W'(1));
    assign period_end = ctrl.run && (ctrl.center ? (dir_dn && (cnt == '0)) : at_top);
    assign reload_evt = period_end && (per_cnt >= ctrl.div);

    // per-line compare: full duty forces active, else active below duty
    for (genvar k = 0; k < NPAIR; k++) begin : g_cmp
        assign raw_top[k] = ctrl.run && ((dtop_act[k] >= mod_act) || (cnt < dtop_act[k]));
        assign raw_bot[k] = ctrl.run && ((dbot_act[k] >= mod_act) || (cnt < dbot_act[k]));
    end

    // counter: sawtooth, or up/down holding each end value for one extra cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl.run) begin
            cnt    <= '0;
            dir_dn <= 1'b0;
        end else if (!ctrl.center) begin
            dir_dn <= 1'b0;
            cnt    <= at_top ? '0 : cnt + CNT_W'(1);
        end else if (!dir_dn) begin
            if (at_top) dir_dn <= 1'b1;
            else        cnt    <= cnt + CNT_W'(1);
        end else begin
            if (cnt == '0) dir_dn <= 1'b0;
            else           cnt    <= cnt - CNT_W'(1);
        end
    end

    // reload divider and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt  <= '0;
            mod_act  <= MOD_MIN;
            dtop_act <= '0;
            dbot_act <= '0;
        end else if (!ctrl.run) begin
            per_cnt  <= '0;
            mod_act  <= mod_eff;
            dtop_act <= dtop_buf;
            dbot_act <= dbot_buf;
        end else if (period_end) begin
            if (reload_evt) begin
                per_cnt  <= '0;
                mod_act  <= mod_eff;
                dtop_act <= dtop_buf;
                dbot_act <= dbot_buf;
            end else begin
                per_cnt <= per_cnt + 4'd1;
            end
        end
    end

    // R4: while running the count stays below the working modulus
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.run |-> (cnt < mod_act));

    // R7: a running counter changes its modulus only at a reload
    assert_mod_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl.run) && !$stable(mod_act)) |-> $past(reload_evt));

endmodule

// File: rtl/cpwm_deadtime.sv
// cpwm_deadtime: output stage of one pair. In complementary mode the top
// request drives both lines and every change blanks both for dt cycles;
// in independent mode each line registers its own request.
// Assumes: dt is sampled when a switch starts; one cycle of latency.
module cpwm_deadtime #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            indep,
    input  logic [DT_W-1:0] dt,
    input  logic            raw_t,
    input  logic            raw_b,
    output logic            act_t,
    output logic            act_b
);

    logic            cur_t;
    logic            cur_b;
    logic [DT_W-1:0] dt_cnt;
    logic            settled;

    assign settled = (dt_cnt == '0);
    assign act_t   = indep ? cur_t : (cur_t && settled);
    assign act_b   = indep ? cur_b : (!cur_t && settled);

    // track requests and run the blanking counter on each switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_t  <= 1'b0;
            cur_b  <= 1'b0;
            dt_cnt <= '0;
        end else if (indep) begin
            cur_t  <= raw_t;
            cur_b  <= raw_b;
            dt_cnt <= '0;
        end else if (raw_t != cur_t) begin
            cur_t  <= raw_t;
            cur_b  <= !raw_t;
            dt_cnt <= dt;
        end else if (!settled) begin
            dt_cnt <= dt_cnt - DT_W'(1);
        end
    end

    // R2: with a dead time, the bottom never follows the top without a gap
    assert_gap_after_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!indep && $past(!indep) && $past(dt != '0) && $past(act_t)) |-> !act_b);

    // R2: with a dead time, the top never follows the bottom without a gap
    assert_gap_after_bot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!indep && $past(!indep) && $past(dt != '0) && $past(act_b)) |-> !act_t);

endmodule

// File: rtl/cpwm_dt.sv
// cpwm_dt: three-pair PWM generator top. Connects the register file, the
// shared timebase and one dead-time stage per pair, then applies fault
// blanking, run gating and per-side polarity.
// Assumes: fault_in is already synchronous to clk.
module cpwm_dt
    import cpwm_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int CNT_W = 8,
    parameter int DT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              fault_in,
    output logic [NPAIR-1:0]  pwm_top,
    output logic [NPAIR-1:0]  pwm_bot,
    output logic              reload_irq,
    output logic              fault_flag
);

    ctrl_t                       ctrl;
    logic [NPAIR-1:0]            indep;
    logic                        pol_top, pol_bot;
    logic [DT_W-1:0]             dt;
    logic [CNT_W-1:0]            mod_buf;
    logic [NPAIR-1:0][CNT_W-1:0] dtop_buf, dbot_buf;
    logic                        locked;
    logic                        period_end, reload_evt;
    logic [NPAIR-1:0]            raw_top, raw_bot, act_top, act_bot;
    logic                        blocked;
    logic                        drive_en;

    cpwm_regs #(.NPAIR(NPAIR), .CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .reload_evt(reload_evt), .fault_in(fault_in), .ctrl(ctrl), .indep(indep),
        .pol_top(pol_top), .pol_bot(pol_bot), .dt(dt), .mod_buf(mod_buf),
        .dtop_buf(dtop_buf), .dbot_buf(dbot_buf), .reload_flag(reload_irq),
        .fault_flag(fault_flag), .locked(locked)
    );

    cpwm_timebase #(.NPAIR(NPAIR), .CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mod_buf(mod_buf),
        .dtop_buf(dtop_buf), .dbot_buf(dbot_buf), .raw_top(raw_top), .raw_bot(raw_bot),
        .period_end(period_end), .reload_evt(reload_evt)
    );

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        cpwm_deadtime #(.DT_W(DT_W)) u_dt (
            .clk(clk), .rst_n(rst_n), .indep(indep[k]), .dt(dt),
            .raw_t(raw_top[k]), .raw_b(raw_bot[k]),
            .act_t(act_top[k]), .act_b(act_bot[k])
        );
    end

    // fault blanking: held from a fault until flag cleared, input low and a period ends
    always_ff @(posedge clk) begin
        if (!rst_n)                                   blocked <= 1'b0;
        else if (fault_in)                            blocked <= 1'b1;
        else if (blocked && !fault_flag && period_end) blocked <= 1'b0;
    end

    assign drive_en = ctrl.run && !blocked && !fault_in;
    assign pwm_top  = {NPAIR{pol_top}} ^ (act_top & {NPAIR{drive_en}});
    assign pwm_bot  = {NPAIR{pol_bot}} ^ (act_bot & {NPAIR{drive_en}});

    // R9: a fault request idles every pin in the same cycle
    assert_fault_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |-> (pwm_top == {NPAIR{pol_top}} && pwm_bot == {NPAIR{pol_bot}}));

    // R10: an uncleared fault flag keeps every pin idle
    assert_flag_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> (pwm_top == {NPAIR{pol_top}} && pwm_bot == {NPAIR{pol_bot}}));

    // R12: a stopped generator keeps every pin idle
    assert_stop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> (pwm_top == {NPAIR{pol_top}} && pwm_bot == {NPAIR{pol_bot}}));

endmodule

// File: tb/cpwm_dt_bench.sv
// cpwm_dt_bench: directed bench, one task per scenario. Counts pin-high
// cycles over whole numbers of periods and compares with duty arithmetic.
module cpwm_dt_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fault_in = 1'b0;
    logic [2:0]  pwm_top, pwm_bot;
    logic        reload_irq, fault_flag;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    int hi_t[3];
    int hi_b[3];
    int ov[3];

    cpwm_dt u_cpwm_dt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault_in(fault_in), .pwm_top(pwm_top), .pwm_bot(pwm_bot),
        .reload_irq(reload_irq), .fault_flag(fault_flag)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int n);
        for (int k = 0; k < 3; k++) begin hi_t[k] = 0; hi_b[k] = 0; ov[k] = 0; end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                if (pwm_top[k]) hi_t[k]++;
                if (pwm_bot[k]) hi_b[k]++;
                if (pwm_top[k] && pwm_bot[k]) ov[k]++;
            end
        end
    endtask

    task automatic wait_irq(output int t);
        t = -1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (reload_irq) begin t = cyc; break; end
        end
    endtask

    task automatic setup_edge(input logic [15:0] cfg, input int m, input int d0, input int d1, input int d2);
        wr(4'd0, 16'h0000);
        wr(4'd1, cfg);
        wr(4'd2, 16'(m));
        wr(4'd3, 16'(d0));
        wr(4'd4, 16'(d1));
        wr(4'd5, 16'(d2));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pwm_top == 3'b000, "R1 top idle", int'(pwm_top), 0);
        chk(pwm_bot == 3'b000, "R1 bottom idle", int'(pwm_bot), 0);
        chk(reload_irq == 1'b0, "R1 reload flag", int'(reload_irq), 0);
        chk(fault_flag == 1'b0, "R1 fault flag", int'(fault_flag), 0);
    endtask

    task automatic t_edge();
        setup_edge(16'h0000, 10, 3, 5, 10);
        wr(4'd0, 16'h0001);
        repeat (30) @(negedge clk);
        measure(100);
        chk(hi_t[0] == 30, "R4 edge top pair0", hi_t[0], 30);
        chk(hi_b[0] == 70, "R4 edge bottom pair0", hi_b[0], 70);
        chk(hi_t[1] == 50, "R4 edge top pair1", hi_t[1], 50);
        chk(hi_t[2] == 100, "R6 full duty top pair2", hi_t[2], 100);
        chk(hi_b[2] == 0, "R6 full duty bottom pair2", hi_b[2], 0);
        wr(4'd1, 16'h0200);
        repeat (30) @(negedge clk);
        measure(100);
        chk(hi_t[0] == 10, "R2 dead time top pair0", hi_t[0], 10);
        chk(hi_b[0] == 50, "R2 dead time bottom pair0", hi_b[0], 50);
        chk(hi_t[1] == 30, "R2 dead time top pair1", hi_t[1], 30);
        chk(hi_b[1] == 30, "R2 dead time bottom pair1", hi_b[1], 30);
        chk(ov[0] + ov[1] + ov[2] == 0, "R2 no overlap", ov[0] + ov[1] + ov[2], 0);
        chk(hi_t[2] == 100, "R6 full duty no gap", hi_t[2], 100);
    endtask

    task automatic t_center();
        setup_edge(16'h0100, 8, 3, 0, 8);
        wr(4'd0, 16'h0003);
        repeat (40) @(negedge clk);
        measure(160);
        chk(hi_t[0] == 50, "R5 center top pair0", hi_t[0], 50);
        chk(hi_b[0] == 90, "R5 center bottom pair0", hi_b[0], 90);
        chk(hi_t[1] == 0, "R6 zero duty top pair1", hi_t[1], 0);
        chk(hi_b[1] == 160, "R6 zero duty bottom no gap", hi_b[1], 160);
        chk(hi_t[2] == 160, "R6 full duty center pair2", hi_t[2], 160);
    endtask

    task automatic t_indep();
        setup_edge(16'h0302, 10, 3, 3, 3);
        wr(4'd7, 16'd6);
        wr(4'd0, 16'h0001);
        repeat (30) @(negedge clk);
        measure(100);
        chk(hi_t[1] == 30, "R3 independent top pair1", hi_t[1], 30);
        chk(hi_b[1] == 60, "R3 independent bottom pair1", hi_b[1], 60);
        chk(ov[1] == 30, "R3 independent overlap allowed", ov[1], 30);
        chk(hi_t[0] == 0, "R2 dead time eats duty pair0", hi_t[0], 0);
        chk(hi_b[0] == 40, "R2 long dead time bottom pair0", hi_b[0], 40);
        chk(ov[0] == 0, "R2 complementary pair0 no overlap", ov[0], 0);
    endtask

    task automatic t_reload();
        int t1, t2;
        setup_edge(16'h0000, 10, 2, 0, 0);
        wr(4'd0, 16'h000D);
        wr(4'd10, 16'h0001);
        wait_irq(t1);
        wr(4'd10, 16'h0001);
        chk(reload_irq == 1'b0, "R7 flag cleared by write", int'(reload_irq), 0);
        wait_irq(t2);
        chk(t1 >= 0 && t2 - t1 == 40, "R7 reload every 4 periods", t2 - t1, 40);
        wr(4'd10, 16'h0001);
        wr(4'd3, 16'd7);
        measure(30);
        chk(hi_t[0] == 6, "R7 shadow duty not yet used", hi_t[0], 6);
        wait_irq(t1);
        repeat (2) @(negedge clk);
        measure(30);
        chk(hi_t[0] == 21, "R7 shadow duty used after reload", hi_t[0], 21);
    endtask

    task automatic t_polarity();
        setup_edge(16'h0008, 10, 3, 5, 10);
        @(negedge clk);
        chk(pwm_top == 3'b111 && pwm_bot == 3'b000, "R12 stopped idle levels", int'({pwm_top, pwm_bot}), 56);
        wr(4'd0, 16'h0001);
        repeat (30) @(negedge clk);
        measure(100);
        chk(hi_t[0] == 70, "R8 inverted top pair0", hi_t[0], 70);
        chk(hi_t[2] == 0, "R8 inverted top full duty", hi_t[2], 0);
        chk(hi_b[0] == 70, "R8 bottom not inverted", hi_b[0], 70);
    endtask

    task automatic t_fault();
        int act;
        @(negedge clk);
        fault_in = 1'b1;
        #1;
        chk(pwm_top == 3'b111 && pwm_bot == 3'b000, "R9 same-cycle idle", int'({pwm_top, pwm_bot}), 56);
        @(negedge clk);
        chk(fault_flag == 1'b1, "R9 fault flag set", int'(fault_flag), 1);
        fault_in = 1'b0;
        measure(50);
        act = (50 - hi_t[0]) + (50 - hi_t[1]) + hi_b[0] + hi_b[1];
        chk(act == 0, "R10 idle until flag cleared", act, 0);
        wr(4'd10, 16'h0002);
        chk(fault_flag == 1'b0, "R10 flag cleared", int'(fault_flag), 0);
        repeat (30) @(negedge clk);
        measure(100);
        chk(hi_t[0] == 70, "R10 resumed top pair0", hi_t[0], 70);
        chk(hi_b[1] == 50, "R10 resumed bottom pair1", hi_b[1], 50);
    endtask

    task automatic t_lock();
        wr(4'd9, 16'h0001);
        wr(4'd1, 16'h0500);
        repeat (30) @(negedge clk);
        measure(100);
        chk(hi_t[0] == 70, "R11 locked polarity kept", hi_t[0], 70);
        chk(hi_b[0] == 70, "R11 locked dead time kept", hi_b[0], 70);
        wr(4'd0, 16'h0000);
        @(negedge clk);
        chk(pwm_top == 3'b111 && pwm_bot == 3'b000, "R12 stop still works when locked", int'({pwm_top, pwm_bot}), 56);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge();
        t_center();
        t_indep();
        t_reload();
        t_polarity();
        t_fault();
        t_lock();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=finish", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule